// File: doc/BRIEF.md
# Serial Bus Request Stream Generator

This block turns a parallel bus request into the serial request stream that a link sends to a physical-layer device. A request kind and a speed are presented together with a one-cycle load strobe. When the generator is idle and the pair is legal, it builds an 8-bit frame and shifts it out one bit per system clock. The frame carries a constant start bit, the kind field, the speed field and a constant stop bit. A busy output covers the frame, and a done pulse marks its final bit.

A repeat input keeps the generator sending frames with no gap. The PHY therefore sees a pending request even when no controller is attached. In repeat mode the frame sent is the last one accepted. If nothing has been accepted since reset, it is a fair request at the top speed, set by parameters. An illegal load is refused and answered with a one-cycle reject pulse. A load that arrives while a frame is running is ignored.

Top module: `breq_serializer`

## Requirements
- R1: Frame layout by index: index 0 is 1, indices 1..3 carry the kind MSB first (index 1 = kind[2], index 3 = kind[0]), indices 4..6 carry the speed MSB first (index 4 = speed[2], index 6 = speed[0]), index 7 is 0.
- R2: Bits leave on `ser_o` in index order, one per clock. Index 0 is driven in the cycle after the clock edge that samples an accepted load.
- R3: With no frame in progress, `ser_o`, `busy_o` and `frame_done_o` are 0.
- R4: Kind codes 000 to 110 are legal. Kind 111 is refused: no frame starts, and `reject_o` is 1 for exactly the one cycle after the sampling edge.
- R5: Only speed codes 000, 010 and 100 are legal. Any other speed is refused in the same way as R4.
- R6: A load sampled while `busy_o` is 1 is ignored. The running frame continues unchanged, `reject_o` stays 0, and no extra frame follows.
- R7: `busy_o` stays high for exactly 8 cycles per frame. `frame_done_o` is high only in the cycle that drives index 7.
- R8: While `repeat_i` is 1, each frame's index 7 is followed in the next cycle by the next frame's index 0. When `repeat_i` is 0 at the edge that ends a frame, the line returns to idle.
- R9: If `repeat_i` is raised before any load has been accepted since reset, frames of kind 011 (fair) and speed 100 (top rate) are sent.
- R10: In repeat mode the frame sent is the most recently accepted one.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY system clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe to accept a request |
| kind_i | input | 3 | Request kind code |
| speed_i | input | 3 | Request speed code |
| repeat_i | input | 1 | Send frames back to back |
| ser_o | output | 1 | Serial request line |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | High during the stop bit |
| reject_o | output | 1 | One-cycle pulse after a refused load |

## Verification
The first bit appears one cycle after the edge that samples the load or the repeat request. The stop bit lands seven cycles after that, and the reject pulse is due one cycle after the sampling edge. The bench therefore queues the expected bits only after the load edge has passed. A monitor pops one item per cycle at the falling edge, and expects an idle line whenever the queue is empty. For repeat runs, `repeat_i` is dropped inside the last expected frame, so that the frame still completes in full and the line then falls idle on the predicted cycle.

// File: rtl/breq_pkg.sv
package breq_pkg;

    localparam int FRAME_W = 8;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        RQ_IMMED  = 3'b000,
        RQ_ISOCH  = 3'b001,
        RQ_PRIO   = 3'b010,
        RQ_FAIR   = 3'b011,
        RQ_REG_RD = 3'b100,
        RQ_REG_WR = 3'b101,
        RQ_ACCEL  = 3'b110,
        RQ_RSVD   = 3'b111
    } rq_kind_e;

    localparam logic [2:0] SP_LOW  = 3'b000;
    localparam logic [2:0] SP_MID  = 3'b010;
    localparam logic [2:0] SP_HIGH = 3'b100;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] speed;
    } rq_cmd_t;

    typedef logic [FRAME_W-1:0] rq_frame_t;

    function automatic logic speed_legal(input logic [2:0] s);
        return (s == SP_LOW) || (s == SP_MID) || (s == SP_HIGH);
    endfunction

    function automatic logic kind_legal(input logic [2:0] k);
        return k != RQ_RSVD;
    endfunction

    // index 0 start, 1..3 kind MSB first, 4..6 speed MSB first, 7 stop
    function automatic rq_frame_t build_frame(input rq_cmd_t c);
        rq_frame_t f;
        f[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            f[1+i] = c.kind[2-i];
            f[4+i] = c.speed[2-i];
        end
        f[7] = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/breq_check.sv
module breq_check
    import breq_pkg::*;
(
    input  rq_cmd_t cmd,
    output logic    legal
);
    always_comb begin
        legal = kind_legal(cmd.kind) && speed_legal(cmd.speed);
    end
endmodule

// File: rtl/breq_piso.sv
module breq_piso #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par,
    output logic         ser
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= par;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[W-1:1]};
        end
    end

    assign ser = sr_q[0];
endmodule

// File: rtl/breq_seq.sv
module breq_seq
    import breq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic cmd_ok,
    input  logic repeat_i,
    output logic take_new,
    output logic start,
    output logic busy,
    output logic last,
    output logic reject
);
    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic             reject_q;

    always_comb begin
        last     = busy_q && (idx_q == IDX_W'(FRAME_W - 1));
        take_new = load_i && !busy_q && cmd_ok;
        start    = take_new || (!busy_q && repeat_i) || (last && repeat_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            idx_q    <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= load_i && !busy_q && !cmd_ok;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end else if (last) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign reject = reject_q;

    // R7: a frame never ends before its last index
    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> busy_q);

    // R4: a reject pulse follows only a load sampled while idle
    assert_reject_cause_R4: assert property (@(posedge clk) disable iff (rst)
        reject_q |-> ($past(load_i) && !$past(busy_q)));
endmodule

// File: rtl/breq_serializer.sv
module breq_serializer
    import breq_pkg::*;
#(
    parameter logic [2:0] DEF_KIND  = 3'b011,
    parameter logic [2:0] DEF_SPEED = 3'b100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [2:0] kind_i,
    input  logic [2:0] speed_i,
    input  logic       repeat_i,
    output logic       ser_o,
    output logic       busy_o,
    output logic       frame_done_o,
    output logic       reject_o
);
    localparam rq_cmd_t   DEF_CMD   = '{kind: DEF_KIND, speed: DEF_SPEED};
    localparam rq_frame_t DEF_FRAME = build_frame(DEF_CMD);

    rq_cmd_t   cmd;
    logic      cmd_ok;
    logic      take_new, start, busy, last;
    logic      piso_bit;
    rq_frame_t word_q, next_word;

    assign cmd = '{kind: kind_i, speed: speed_i};

    breq_check u_check (
        .cmd   (cmd),
        .legal (cmd_ok)
    );

    breq_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .cmd_ok   (cmd_ok),
        .repeat_i (repeat_i),
        .take_new (take_new),
        .start    (start),
        .busy     (busy),
        .last     (last),
        .reject   (reject_o)
    );

    always_comb begin
        next_word = take_new ? build_frame(cmd) : word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= DEF_FRAME;
        end else if (take_new) begin
            word_q <= next_word;
        end
    end

    breq_piso #(.W(FRAME_W)) u_piso (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .shift (busy),
        .par   (next_word),
        .ser   (piso_bit)
    );

    assign busy_o       = busy;
    assign frame_done_o = last;
    assign ser_o        = busy & piso_bit;

    // R1: every frame opens with a 1
    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ser_o);

    // R1: the stop bit is 0
    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> !ser_o);

    // R3: the line rests low when idle
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ser_o);

    // R8: back-to-back frames in repeat mode
    assert_no_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_done_o && repeat_i) |=> (busy_o && ser_o));

    // R8: the line releases after a final frame
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_done_o && !repeat_i) |=> !busy_o);
endmodule

// File: tb/sim_breq_serializer.sv
module sim_breq_serializer;

    typedef struct {
        logic  ser;
        logic  done;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [2:0] kind_i = 3'b000;
    logic [2:0] speed_i = 3'b000;
    logic       repeat_i = 1'b0;
    logic       ser_o, busy_o, frame_done_o, reject_o;

    int n_cmp = 0;
    int n_bad = 0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    breq_serializer u0 (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .kind_i       (kind_i),
        .speed_i      (speed_i),
        .repeat_i     (repeat_i),
        .ser_o        (ser_o),
        .busy_o       (busy_o),
        .frame_done_o (frame_done_o),
        .reject_o     (reject_o)
    );

    function automatic logic [7:0] ref_frame(input logic [2:0] k, input logic [2:0] s);
        logic [7:0] f;
        f[0] = 1'b1; f[1] = k[2]; f[2] = k[1]; f[3] = k[0];
        f[4] = s[2]; f[5] = s[1]; f[6] = s[0]; f[7] = 1'b0;
        return f;
    endfunction

    task automatic check1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_frame(input logic [7:0] f, input string tag);
        for (int i = 0; i < 8; i++) exp_q.push_back('{f[i], (i == 7), tag});
    endtask

    // monitor: one expected item per cycle, idle when queue is empty
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check1({it.tag, " ser"}, ser_o, it.ser);
                check1({it.tag, " busy"}, busy_o, 1'b1);
                check1({it.tag, " done"}, frame_done_o, it.done);
            end else begin
                check1("R3 idle ser", ser_o, 1'b0);
                check1("R3 idle busy", busy_o, 1'b0);
                check1("R3 idle done", frame_done_o, 1'b0);
            end
        end
    end

    // legal load: frame expected from the edge after the strobe
    task automatic do_load(input logic [2:0] k, input logic [2:0] s, input string tag);
        @(posedge clk); #1;
        load_i = 1'b1; kind_i = k; speed_i = s;
        @(posedge clk); #1;
        load_i = 1'b0;
        push_frame(ref_frame(k, s), tag);
        check1({tag, " no reject"}, reject_o, 1'b0);
    endtask

    task automatic do_bad_load(input logic [2:0] k, input logic [2:0] s, input string tag);
        @(posedge clk); #1;
        load_i = 1'b1; kind_i = k; speed_i = s;
        @(posedge clk); #1;
        load_i = 1'b0;
        check1({tag, " reject pulse"}, reject_o, 1'b1);
        @(posedge clk); #1;
        check1({tag, " reject one cycle"}, reject_o, 1'b0);
    endtask

    task automatic wait_drain();
        while (exp_q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic run_repeat(input int n, input logic [7:0] f, input string tag);
        @(posedge clk); #1;
        repeat_i = 1'b1;
        @(posedge clk); #1;
        for (int j = 0; j < n; j++) push_frame(f, tag);
        repeat (8 * n - 1) @(posedge clk);
        #1 repeat_i = 1'b0;
        wait_drain();
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check1("R11 ser", ser_o, 1'b0);
        check1("R11 busy", busy_o, 1'b0);
        check1("R11 done", frame_done_o, 1'b0);
        check1("R11 reject", reject_o, 1'b0);

        // R9 and R8: default fair request at top speed, back to back
        run_repeat(3, ref_frame(3'b011, 3'b100), "R9_R8 default");

        // R1, R2, R7: assorted legal kinds and speeds
        do_load(3'b011, 3'b100, "R1 fair/high");   wait_drain();
        do_load(3'b000, 3'b000, "R2 immed/low");   wait_drain();
        do_load(3'b001, 3'b010, "R7 isoch/mid");   wait_drain();
        do_load(3'b101, 3'b100, "R1 regwr/high");  wait_drain();
        do_load(3'b110, 3'b010, "R2 accel/mid");   wait_drain();

        // R4: reserved kind refused
        do_bad_load(3'b111, 3'b000, "R4 kind 111");
        wait_drain();

        // R5: invalid speeds refused
        do_bad_load(3'b011, 3'b001, "R5 speed 001");
        do_bad_load(3'b010, 3'b011, "R5 speed 011");
        do_bad_load(3'b000, 3'b111, "R5 speed 111");
        do_bad_load(3'b100, 3'b110, "R5 speed 110");
        wait_drain();

        // R6: load while busy is ignored
        do_load(3'b100, 3'b000, "R6 first");
        repeat (3) @(posedge clk);
        #1 load_i = 1'b1; kind_i = 3'b111; speed_i = 3'b101;
        @(posedge clk); #1 load_i = 1'b0;
        check1("R6 no reject while busy", reject_o, 1'b0);
        @(posedge clk); #1 load_i = 1'b1; kind_i = 3'b010; speed_i = 3'b010;
        @(posedge clk); #1 load_i = 1'b0;
        wait_drain();

        // R10: repeat sends the last accepted frame
        do_load(3'b010, 3'b010, "R10 load");
        wait_drain();
        run_repeat(2, ref_frame(3'b010, 3'b010), "R10 repeat");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule